// File: doc/BRIEF.md
# Serial Audio Control Register with Zero-Cross Commit

This block receives a 32-bit control word over a three-wire serial link (data, shift clock, chip-enable) and holds the settings of a stereo audio processing channel: source selection, loudness switch, per-channel coarse and fine attenuation, bass and treble level with boost or cut, and front/rear fader attenuation. All three serial lines and the zero-cross flag come from outside the system clock domain and pass through synchronizer flops before use.

A completed transfer (chip-enable falling) does not change the outputs at once. The captured word waits as a pending update and is copied into the active settings on the next rising edge of the zero-cross input, so that attenuator steps land where the audio waveform is near zero. If no zero-crossing arrives within a programmable number of system clock cycles, the update is forced. With a 1 MHz system clock the default wait of 500 cycles is 500 µs.

Top module: `volctl_serial_top`

## Requirements
- R1: While serCe is high, each rising edge of serClk shifts serData into the receive register; the first bit of a transfer is word bit 1 (most significant) and the 32nd is word bit 32.
- R2: The active word drives the outputs as follows (word bit numbers): inSel = bits 3..4, loudOn = bit 5, ch1Coarse = 6..9, ch1Fine = 10..12, ch2Coarse = 13..16, ch2Fine = 17..19, bassLvl = 20..22, bassBoost = 23, trebLvl = 24..26, trebBoost = 27, fadeAtt = 28..31, fadeFront = 32; lower bit numbers are the more significant bits of each field; bits 1..2 are discarded.
- R3: A falling edge of serCe captures the receive register as a pending word; the outputs keep their previous values until that word is committed.
- R4: A rising edge of zeroCross while a word is pending copies it to the outputs within a few cycles; the outputs change at no other time except under R5.
- R5: If no zeroCross rising edge occurs, a pending word reaches the outputs TIMEOUT_CYC system cycles (plus synchronizer delay) after the serCe falling edge.
- R6: After reset the receive, pending and active words hold the reset values: inSel 00 (input 1), loudOn 0, both coarse 0000 and fine 000 (muted), bass and treble level 000 with boost bit 0, fadeAtt 1111 (0 dB), fadeFront 0 (rear targeted).
- R7: When more than 32 bits are shifted in one transfer, only the last 32 determine the captured word.
- R8: serClk edges while serCe is low do not alter the receive register.
- R9: A serCe falling edge while an update is pending replaces the pending word and restarts the timeout count.
- R10: A zeroCross rising edge with no word pending leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock |
| serCe | input | 1 | Serial chip-enable, transfer ends on its falling edge |
| zeroCross | input | 1 | Audio zero-cross flag, rising edge is the event |
| inSel | output | 2 | Active source selection |
| loudOn | output | 1 | Loudness enable |
| ch1Coarse | output | 4 | Channel 1 coarse attenuation code |
| ch1Fine | output | 3 | Channel 1 fine attenuation code |
| ch2Coarse | output | 4 | Channel 2 coarse attenuation code |
| ch2Fine | output | 3 | Channel 2 fine attenuation code |
| bassLvl | output | 3 | Bass level code |
| bassBoost | output | 1 | Bass direction, 1 boost, 0 cut |
| trebLvl | output | 3 | Treble level code |
| trebBoost | output | 1 | Treble direction, 1 boost, 0 cut |
| fadeAtt | output | 4 | Fader attenuation code |
| fadeFront | output | 1 | Fader target, 1 front, 0 rear |

## Verification
Words are delivered and committed three ways: by a zero-cross pulse, by letting the timeout run out, and by a second transfer that lands mid-wait, which separates a counter that restarts from one that keeps running from the first capture. An alternating word, an all-ones word and an all-zeros word sent as a 40-bit overlong transfer tell apart swapped or shifted fields and an overflow that keeps the first bits instead of the last. Shift clocks during chip-enable low followed by an empty transfer, and a zero-cross pulse with nothing pending, show whether either stray stimulus reaches the outputs.

// File: rtl/volctl_pkg.sv
package volctl_pkg;

  // Full serial word length and the part of it that carries settings
  localparam int WORD_BITS = 32;
  localparam int NOP_BITS  = 2;
  localparam int ACT_BITS  = WORD_BITS - NOP_BITS;

  // Settings word after reset: fader field at 0 dB (all ones), all else zero
  localparam logic [ACT_BITS-1:0] RESET_WORD = ACT_BITS'(30'h0000_001E);

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic capture;
    logic commit;
  } volStrobe_t;

endpackage

// File: rtl/volctl_sync.sv
module volctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= '0;
        end else if (s == 0) begin
          stage[s] <= asyncIn;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/volctl_ctrl.sv
module volctl_ctrl
  import volctl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclkS,
  input  logic       ceS,
  input  logic       zcS,
  output volStrobe_t strb
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             sclkPrev, cePrev, zcPrev;
  logic             pending;
  logic [CNT_W-1:0] waitCnt;
  logic             sclkRise, ceFall, zcRise, timeUp;

  assign sclkRise = sclkS & ~sclkPrev;
  assign ceFall   = cePrev & ~ceS;
  assign zcRise   = zcS & ~zcPrev;
  assign timeUp   = pending && (waitCnt == CNT_LAST);

  // A fresh capture wins over a commit in the same cycle
  always_comb begin
    strb.shiftEn = sclkRise & ceS;
    strb.capture = ceFall;
    strb.commit  = pending & (zcRise | timeUp) & ~ceFall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      cePrev   <= 1'b0;
      zcPrev   <= 1'b0;
      pending  <= 1'b0;
      waitCnt  <= '0;
    end else begin
      sclkPrev <= sclkS;
      cePrev   <= ceS;
      zcPrev   <= zcS;
      if (strb.capture) begin
        pending <= 1'b1;
        waitCnt <= '0;
      end else if (strb.commit) begin
        pending <= 1'b0;
        waitCnt <= '0;
      end else if (pending) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> waitCnt <= CNT_LAST); // R5

  AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && waitCnt == CNT_LAST && !ceFall) |=> !pending); // R5

  AST_CAPTURE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ceFall |=> (pending && waitCnt == '0)); // R9

endmodule

// File: rtl/volctl_dpath.sv
module volctl_dpath
  import volctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dataS,
  input  volStrobe_t          strb,
  output logic [ACT_BITS-1:0] activeWord
);

  // Only the last ACT_BITS shifted bits reach the settings, so the two
  // leading no-op bits need no storage.
  logic [ACT_BITS-1:0] shiftWord;
  logic [ACT_BITS-1:0] pendWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftWord  <= RESET_WORD;
      pendWord   <= RESET_WORD;
      activeWord <= RESET_WORD;
    end else begin
      if (strb.shiftEn) shiftWord  <= {shiftWord[ACT_BITS-2:0], dataS};
      if (strb.capture) pendWord   <= shiftWord;
      if (strb.commit)  activeWord <= pendWord;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(activeWord)); // R4

  AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> activeWord == $past(pendWord)); // R3

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> $stable(shiftWord)); // R8

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(pendWord)); // R3

  AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.capture && strb.commit)); // R9

endmodule

// File: rtl/volctl_serial_top.sv
module volctl_serial_top
  import volctl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serData,
  input  logic       serClk,
  input  logic       serCe,
  input  logic       zeroCross,
  output logic [1:0] inSel,
  output logic       loudOn,
  output logic [3:0] ch1Coarse,
  output logic [2:0] ch1Fine,
  output logic [3:0] ch2Coarse,
  output logic [2:0] ch2Fine,
  output logic [2:0] bassLvl,
  output logic       bassBoost,
  output logic [2:0] trebLvl,
  output logic       trebBoost,
  output logic [3:0] fadeAtt,
  output logic       fadeFront
);

  logic [3:0]          syncBus;
  volStrobe_t          strb;
  logic [ACT_BITS-1:0] activeWord;

  volctl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({zeroCross, serCe, serClk, serData}),
    .syncOut (syncBus)
  );

  volctl_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .sclkS (syncBus[1]),
    .ceS   (syncBus[2]),
    .zcS   (syncBus[3]),
    .strb  (strb)
  );

  volctl_dpath u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .dataS      (syncBus[0]),
    .strb       (strb),
    .activeWord (activeWord)
  );

  // Word bit n sits at activeWord[WORD_BITS-n]
  assign inSel     = activeWord[29:28];
  assign loudOn    = activeWord[27];
  assign ch1Coarse = activeWord[26:23];
  assign ch1Fine   = activeWord[22:20];
  assign ch2Coarse = activeWord[19:16];
  assign ch2Fine   = activeWord[15:13];
  assign bassLvl   = activeWord[12:10];
  assign bassBoost = activeWord[9];
  assign trebLvl   = activeWord[8:6];
  assign trebBoost = activeWord[5];
  assign fadeAtt   = activeWord[4:1];
  assign fadeFront = activeWord[0];

endmodule

// File: tb/volctl_serial_top_tb.sv
module volctl_serial_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 500;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serCe = 1'b1, zeroCross = 1'b0;
  logic [1:0] inSel;
  logic loudOn, bassBoost, trebBoost, fadeFront;
  logic [3:0] ch1Coarse, ch2Coarse, fadeAtt;
  logic [2:0] ch1Fine, ch2Fine, bassLvl, trebLvl;

  int vecCnt = 0;
  int missCnt = 0;
  bit done = 0;
  logic [29:0] expQ[$];
  logic [29:0] lastSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  volctl_serial_top #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .serData(serData), .serClk(serClk),
    .serCe(serCe), .zeroCross(zeroCross), .inSel(inSel), .loudOn(loudOn),
    .ch1Coarse(ch1Coarse), .ch1Fine(ch1Fine), .ch2Coarse(ch2Coarse),
    .ch2Fine(ch2Fine), .bassLvl(bassLvl), .bassBoost(bassBoost),
    .trebLvl(trebLvl), .trebBoost(trebBoost), .fadeAtt(fadeAtt),
    .fadeFront(fadeFront)
  );

  // Outputs in word bit order 3..32 (R2)
  function automatic logic [29:0] outVec();
    return {inSel, loudOn, ch1Coarse, ch1Fine, ch2Coarse, ch2Fine,
            bassLvl, bassBoost, trebLvl, trebBoost, fadeAtt, fadeFront};
  endfunction

  // Expected settings from a word: bit n (1 = first sent) is w[32-n]
  function automatic logic [29:0] settingsOf(logic [31:0] w);
    logic [29:0] r;
    for (int n = 3; n <= 32; n++) r[32-n] = w[32-n];
    return r;
  endfunction

  task automatic check(string tag, logic [29:0] act, logic [29:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nBits of bits, MSB first, then drop chip-enable
  task automatic sendBits(logic [63:0] bits, int nBits);
    @(negedge clk);
    serCe = 1'b1;
    waitCyc(8);
    for (int i = nBits - 1; i >= 0; i--) begin
      serData = bits[i];
      waitCyc(HALF_BIT);
      serClk = 1'b1;
      waitCyc(HALF_BIT);
      serClk = 1'b0;
    end
    waitCyc(HALF_BIT);
    serCe = 1'b0;
  endtask

  task automatic pulseZc();
    @(negedge clk);
    zeroCross = 1'b1;
    waitCyc(4);
    zeroCross = 1'b0;
  endtask

  // Monitor: every change of the outputs must match the next expected word
  always @(negedge clk) begin
    if (!rst_n) begin
      lastSeen <= settingsOf(32'h0000_001E);
    end else if (outVec() !== lastSeen) begin
      if (expQ.size() == 0) begin
        vecCnt++;
        missCnt++;
        $display("FAIL R4 unexpected update actual=%h expected=%h", outVec(), lastSeen);
      end else begin
        check("R2 monitor", outVec(), expQ.pop_front());
      end
      lastSeen <= outVec();
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecCnt++;
      missCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] wA, wB, wC, wD, wE;
    wA = 32'h5A3C_96E1;
    wB = 32'hFFFF_FFFF;
    wC = 32'h0000_0000;
    wD = 32'h1234_5678;
    wE = 32'h2AAA_5555;

    waitCyc(5);
    rst_n = 1'b1;
    waitCyc(3);
    // R6: reset settings, input 1, muted, loudness off, fader 0 dB rear
    check("R6 reset", outVec(), 30'h0000_001E);

    // R1 R3 R4: zero-cross commit
    expQ.push_back(settingsOf(wA));
    sendBits({32'h0, wA}, 32);
    waitCyc(40);
    check("R3 held before zero-cross", outVec(), settingsOf(32'h0000_001E));
    pulseZc();
    waitCyc(8);
    check("R4 committed on zero-cross", outVec(), settingsOf(wA));

    // R5: timeout commit, all-ones word
    expQ.push_back(settingsOf(wB));
    sendBits({32'h0, wB}, 32);
    waitCyc(TMO - 20);
    check("R5 held before timeout", outVec(), settingsOf(wA));
    waitCyc(40);
    check("R5 committed at timeout", outVec(), settingsOf(wB));

    // R7: 40 bits, last 32 kept (all-zeros word)
    expQ.push_back(settingsOf(wC));
    sendBits({24'h0, 8'hFF, wC}, 40);
    pulseZc();
    waitCyc(8);
    check("R7 last 32 bits kept", outVec(), settingsOf(wC));

    // R8: shift clocks with chip-enable low, then an empty transfer
    for (int k = 0; k < 12; k++) begin
      serData = k[0];
      waitCyc(HALF_BIT);
      serClk = 1'b1;
      waitCyc(HALF_BIT);
      serClk = 1'b0;
    end
    sendBits(64'h0, 0);
    pulseZc();
    waitCyc(8);
    check("R8 clocks ignored with chip-enable low", outVec(), settingsOf(wC));

    // R10: zero-cross with nothing pending
    pulseZc();
    waitCyc(8);
    check("R10 idle zero-cross no effect", outVec(), settingsOf(wC));

    // R9: second transfer mid-wait replaces word and restarts count
    sendBits({32'h0, wD}, 32);
    waitCyc(100);
    expQ.push_back(settingsOf(wE));
    sendBits({32'h0, wE}, 32);
    waitCyc(150);
    check("R9 restart, old deadline passes", outVec(), settingsOf(wC));
    waitCyc(TMO - 170);
    check("R9 held before restarted timeout", outVec(), settingsOf(wC));
    waitCyc(40);
    check("R9 replaced word committed", outVec(), settingsOf(wE));

    waitCyc(10);
    vecCnt++;
    if (expQ.size() != 0) begin
      missCnt++;
      $display("FAIL R4 missing updates actual=%0d expected=0", expQ.size());
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule